// File: doc/BRIEF.md
# SDRAM Mode Register Command Issuer

This block lets software program the mode and extended-mode registers of a DDR SDRAM. It has a small register port with two 32-bit registers, selected by a single select line. The control register holds a mode-programming enable and the memory clock enable. It also shows a read-only busy flag. The mode register holds a bank selector, a 12-bit address value and a write-only trigger bit.

When software writes the mode register with the trigger set, the programming enable open and the clock enable on, the block drives one load-mode command on the memory pins. During that cycle every chip select is low, RAS, CAS and WE are all low, and the stored bank and address values sit on the bank and address pins. The bank value picks the target: 00 is the standard mode register, 01 is the extended mode register of a standard DDR device, and 10 is the extended mode register of a low-power mobile device. Value 11 is kept in the register but never produces a command. On every other cycle the pins show a no-operation.

Top module: `sdram_mode_cmd`

## Requirements
- R1: After reset, both registers read as zero, memCke is low, and the memory pins show a no-operation.
- R2: The control register (regSel=0) stores the programming enable in bit 31 and the clock enable in bit 30. memCke follows bit 30. Bit 29 reads the busy flag. All other bits read as zero, and write data in them is dropped.
- R3: While the programming enable is 0, a write to the mode register (regSel=1) changes nothing: the readback stays the same and no command is issued.
- R4: The mode register reads back the bank in bits 31:30 and the address in bits 29:18. The trigger bit 16, bit 17 and bits 15:0 always read as zero.
- R5: An accepted trigger drives exactly one command cycle. This is the cycle after the write's clock edge. In it all chip selects, RAS, CAS and WE are low, memBa carries the bank and memAddr carries the address of that write.
- R6: A trigger written while the clock enable is 0 issues no command, but its bank and address are still stored.
- R7: A trigger with bank value 11 stores the fields and issues no command.
- R8: A mode register write with bit 16 at 0 stores the fields and issues no command.
- R9: During a command cycle the busy bit reads 1. A trigger written in that cycle issues no command, but its fields are stored.
- R10: Outside a command cycle the chip selects, RAS, CAS and WE are all high, and memBa and memAddr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 control, 1 mode |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Readback of the selected register |
| memCke | output | 1 | SDRAM clock enable |
| memCsN | output | NUM_CS | SDRAM chip selects, active low |
| memRasN | output | 1 | SDRAM RAS, active low |
| memCasN | output | 1 | SDRAM CAS, active low |
| memWeN | output | 1 | SDRAM WE, active low |
| memBa | output | 2 | SDRAM bank address |
| memAddr | output | ADDR_W | SDRAM address |

## Verification
The assertions check the following on every cycle:
- A command lasts one cycle and then ends.
- A command only appears while the clock enable is on.
- All chip selects move together with RAS, CAS and WE.
- Bank value 11 never reaches the pins.
- The stored fields never change while the lock is closed.
- The idle pins stay at no-operation with zero bank and address.

Only the bench scenarios can show the rest. One part is that each accepted write produces exactly its own command, with the right bank and address. Another is that blocked triggers (clock enable off, bank 11, trigger clear, busy) produce nothing while still storing their fields. The last is that readback masks the reserved and write-only bits.

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;

  typedef struct packed {
    logic ctrlWr;
    logic modeWr;
    logic issue;
  } cmdStrobe_t;

  typedef enum logic [1:0] {
    BANK_LMR      = 2'b00,
    BANK_LEMR_STD = 2'b01,
    BANK_LEMR_MOB = 2'b10,
    BANK_RSVD     = 2'b11
  } bankSel_t;

endpackage

// File: rtl/sdram_mode_ctrl.sv
module sdram_mode_ctrl
  import sdram_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regSel,
  input  logic       trigBit,
  input  logic [1:0] bankWr,
  input  logic       modeEn,
  input  logic       cke,
  output cmdStrobe_t strobe,
  output logic       busy
);

  bankSel_t bankSel;

  always_comb begin
    bankSel       = bankSel_t'(bankWr);
    strobe.ctrlWr = regWrEn && !regSel;
    strobe.modeWr = regWrEn && regSel && modeEn;
    strobe.issue  = strobe.modeWr && cke && trigBit && (bankSel != BANK_RSVD) && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else       busy <= strobe.issue;
  end

  AST_BUSY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy); // R9

  AST_LOCK_NO_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    !modeEn |=> !busy); // R3

endmodule

// File: rtl/sdram_mode_dp.sv
module sdram_mode_dp
  import sdram_mode_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic              regSel,
  input  logic [1:0]        ctrlBits,
  input  logic [1:0]        bankWr,
  input  logic [ADDR_W-1:0] addrWr,
  input  logic              busy,
  output logic              modeEn,
  output logic              cke,
  output logic [DATA_W-1:0] rdData,
  output logic              memCke,
  output logic [NUM_CS-1:0] memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [1:0]        memBa,
  output logic [ADDR_W-1:0] memAddr
);

  localparam int BA_LSB   = DATA_W - 2;
  localparam int ADDR_LSB = BA_LSB - ADDR_W;
  localparam int BUSY_BIT = DATA_W - 3;

  logic [1:0]        modeBa;
  logic [ADDR_W-1:0] modeAddr;
  logic [1:0]        issBa;
  logic [ADDR_W-1:0] issAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeEn   <= 1'b0;
      cke      <= 1'b0;
      modeBa   <= '0;
      modeAddr <= '0;
      issBa    <= '0;
      issAddr  <= '0;
    end else begin
      if (strobe.ctrlWr) {modeEn, cke} <= ctrlBits;
      if (strobe.modeWr) begin
        modeBa   <= bankWr;
        modeAddr <= addrWr;
      end
      if (strobe.issue) begin
        issBa   <= bankWr;
        issAddr <= addrWr;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (regSel) begin
      rdData[DATA_W-1 -: 2]     = modeBa;
      rdData[ADDR_LSB +: ADDR_W] = modeAddr;
    end else begin
      rdData[DATA_W-1] = modeEn;
      rdData[DATA_W-2] = cke;
      rdData[BUSY_BIT] = busy;
    end
  end

  assign memCke  = cke;
  assign memCsN  = busy ? '0 : '1;
  assign memRasN = !busy;
  assign memCasN = !busy;
  assign memWeN  = !busy;
  assign memBa   = busy ? issBa : '0;
  assign memAddr = busy ? issAddr : '0;

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !memRasN |=> memRasN); // R5

  AST_CS_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    ((memCsN == '0) || (memCsN == '1)) && (memCsN[0] == memRasN)
    && (memRasN == memCasN) && (memCasN == memWeN)); // R5

  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rstN)
    !memRasN |-> memCke && modeEn); // R6

  AST_NO_RSVD_BANK: assert property (@(posedge clk) disable iff (!rstN)
    !memRasN |-> memBa != 2'b11); // R7

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(!modeEn) |-> $stable(modeBa) && $stable(modeAddr)); // R3

  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    memRasN |-> (memBa == '0) && (memAddr == '0) && (memCsN == '1)); // R10

endmodule

// File: rtl/sdram_mode_cmd.sv
module sdram_mode_cmd
  import sdram_mode_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              memCke,
  output logic [NUM_CS-1:0] memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [1:0]        memBa,
  output logic [ADDR_W-1:0] memAddr
);

  localparam int BA_LSB   = DATA_W - 2;
  localparam int ADDR_LSB = BA_LSB - ADDR_W;
  localparam int TRIG_BIT = ADDR_LSB - 2;

  cmdStrobe_t strobe;
  logic       busy;
  logic       modeEn;
  logic       cke;
  logic       unusedWrBits;

  assign unusedWrBits = ^{regWrData[ADDR_LSB-1], regWrData[TRIG_BIT-1:0]};

  sdram_mode_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regSel  (regSel),
    .trigBit (regWrData[TRIG_BIT]),
    .bankWr  (regWrData[DATA_W-1 -: 2]),
    .modeEn  (modeEn),
    .cke     (cke),
    .strobe  (strobe),
    .busy    (busy)
  );

  sdram_mode_dp #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_CS (NUM_CS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regSel   (regSel),
    .ctrlBits (regWrData[DATA_W-1 -: 2]),
    .bankWr   (regWrData[DATA_W-1 -: 2]),
    .addrWr   (regWrData[ADDR_LSB +: ADDR_W]),
    .busy     (busy),
    .modeEn   (modeEn),
    .cke      (cke),
    .rdData   (regRdData),
    .memCke   (memCke),
    .memCsN   (memCsN),
    .memRasN  (memRasN),
    .memCasN  (memCasN),
    .memWeN   (memWeN),
    .memBa    (memBa),
    .memAddr  (memAddr)
  );

endmodule

// File: tb/sdram_mode_cmd_test.sv
`timescale 1ns/1ps
module sdram_mode_cmd_test;

  localparam real CLK_PERIOD = 8.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memCke, memRasN, memCasN, memWeN;
  logic [1:0]  memCsN;
  logic [1:0]  memBa;
  logic [11:0] memAddr;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;
  bit prevCmd = 0;

  logic [13:0] expQ[$];

  logic        mEn = 0, mCke = 0, prevIssue = 0;
  logic [1:0]  mBa = 0;
  logic [11:0] mAddr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_mode_cmd uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .memCke(memCke),
    .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memBa(memBa), .memAddr(memAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modeWord(input logic [1:0] ba, input logic [11:0] ad,
                                           input logic trig, input logic [16:0] junk);
    return {ba, ad, junk[16], trig, junk[15:0]};
  endfunction

  // Driver: entered at a negedge, leaves at the next negedge.
  task automatic wr(input logic sel, input logic [31:0] d);
    logic issue;
    issue = 1'b0;
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    if (!sel) begin
      mEn = d[31]; mCke = d[30];
    end else if (mEn) begin
      issue = mCke && d[16] && (d[31:30] != 2'b11) && !prevIssue;
      mBa = d[31:30]; mAddr = d[29:18];
      if (issue) expQ.push_back({d[31:30], d[29:18]});
    end
    @(negedge clk);
    regWrEn = 1'b0;
    prevIssue = issue;
  endtask

  task automatic rd(input logic sel, input string req);
    regSel = sel; regWrEn = 1'b0;
    #1;
    if (sel) check(req, regRdData, {mBa, mAddr, 18'b0});
    else     check(req, regRdData, {mEn, mCke, prevIssue, 29'b0});
    @(negedge clk);
    prevIssue = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    prevIssue = 1'b0;
  endtask

  // Monitor: pops expected commands as the pins show them.
  always @(negedge clk) begin
    if (started && rstN) begin
      if (!memRasN) begin
        checks++;
        if (prevCmd) begin
          errors++;
          $display("FAIL R5: command lasted more than one cycle actual=1 expected=0");
        end
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R6/R7/R8/R9: unexpected command ba=%b addr=%h expected none", memBa, memAddr);
        end else begin
          logic [13:0] e;
          e = expQ.pop_front();
          if ({memBa, memAddr} !== e || memCsN !== 2'b00 || memCasN !== 1'b0 || memWeN !== 1'b0) begin
            errors++;
            $display("FAIL R5: cmd actual=%b/%h cs=%b cas=%b we=%b expected=%b/%h all low",
                     memBa, memAddr, memCsN, memCasN, memWeN, e[13:12], e[11:0]);
          end
        end
      end else begin
        checks++;
        if (memCsN !== 2'b11 || memCasN !== 1'b1 || memWeN !== 1'b1 || memBa !== 2'b00 || memAddr !== 12'h000) begin
          errors++;
          $display("FAIL R10: idle actual cs=%b cas=%b we=%b ba=%b addr=%h expected NOP with zeros",
                   memCsN, memCasN, memWeN, memBa, memAddr);
        end
      end
      prevCmd = !memRasN;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    started = 1;
    // R1 reset state
    check("R1 cke", {31'b0, memCke}, 32'h0);
    check("R1 nop", {29'b0, memRasN, memCasN, memWeN}, 32'h7);
    rd(1'b0, "R1 ctrl");
    rd(1'b1, "R1 mode");
    // R3 locked mode register
    wr(1'b1, modeWord(2'b01, 12'hABC, 1'b1, 17'h0));
    rd(1'b1, "R3 locked write ignored");
    // R2 enable programming, clock still off
    wr(1'b0, 32'h8000_FFFF);
    rd(1'b0, "R2 ctrl readback");
    check("R2 cke low", {31'b0, memCke}, 32'h0);
    // R6 trigger with cke off
    wr(1'b1, modeWord(2'b00, 12'h123, 1'b1, 17'h0));
    rd(1'b1, "R6 fields stored without command");
    // R2 turn clock on, junk in low bits dropped
    wr(1'b0, 32'hC003_1234);
    rd(1'b0, "R2 ctrl readback cke");
    check("R2 cke high", {31'b0, memCke}, 32'h1);
    // R5 standard mode command, R4 reserved bits masked
    wr(1'b1, modeWord(2'b00, 12'h5A5, 1'b1, 17'h1FFFF));
    idle(1);
    rd(1'b1, "R4 reserved and trigger read zero");
    wr(1'b1, modeWord(2'b01, 12'h0F0, 1'b1, 17'h0));
    idle(1);
    wr(1'b1, modeWord(2'b10, 12'hFFF, 1'b1, 17'h0));
    idle(1);
    // R7 reserved bank
    wr(1'b1, modeWord(2'b11, 12'h777, 1'b1, 17'h0));
    rd(1'b1, "R7 bank 11 stored");
    idle(1);
    // R8 trigger clear
    wr(1'b1, modeWord(2'b01, 12'h321, 1'b0, 17'h0));
    rd(1'b1, "R8 fields stored without trigger");
    // R9 busy readback during command
    wr(1'b1, modeWord(2'b00, 12'h042, 1'b1, 17'h0));
    rd(1'b0, "R9 busy reads one");
    rd(1'b0, "R9 busy cleared");
    // R9 back-to-back trigger blocked, fields stored
    wr(1'b1, modeWord(2'b01, 12'h111, 1'b1, 17'h0));
    wr(1'b1, modeWord(2'b10, 12'h222, 1'b1, 17'h0));
    rd(1'b1, "R9 blocked trigger fields stored");
    idle(1);
    // R3 relock with cke on
    wr(1'b0, 32'h4000_0000);
    wr(1'b1, modeWord(2'b00, 12'h999, 1'b1, 17'h0));
    rd(1'b1, "R3 relocked write ignored");
    // R2 clock off
    wr(1'b0, 32'h0000_0000);
    rd(1'b0, "R2 all clear");
    check("R2 cke off", {31'b0, memCke}, 32'h0);
    idle(2);
    check("R5 all expected commands seen", expQ.size(), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule